// File: doc/BRIEF.md
# ADC Burst Start-of-Conversion Sequencer

This block sits in front of an ADC that has sixteen start-of-conversion slots. It watches one hardware trigger, picked from 127 candidates by a 7-bit select field. When burst mode is on, each rising edge on that trigger marks a run of consecutive slots as pending. The run begins at the round-robin pointer and wraps past slot 15 to slot 0. Software can also force any set of slots to pending at any time, with or without a trigger.

Pending slots are handed to the converter one at a time through a request/ready/done handshake. The order is round-robin, starting at the pointer. Each finished conversion moves the pointer to the slot after the one that just converted, so the next burst picks up where the last one stopped. If a burst marks a slot that is still waiting, that slot's sticky overflow flag is raised. Software clears the flag by writing 1 to it.

Top module: `adc_burst_seq`

## Requirements
- R1: After reset the control word reads 0000h, no slot is pending, all overflow flags are 0, the pointer is 0 and no conversion is requested.
- R2: The control word keeps the enable at bit 15, the length code at bits 11:8 and the trigger select at bits 6:0. Bits 14:12 and bit 7 always read 0, so writing FFFFh reads back 8F7Fh.
- R3: While the enable bit is 0, no hardware trigger edge marks any slot.
- R4: A length code k marks k+1 slots in one cycle. The slots are pointer, pointer+1 and so on, counted modulo 16, so slot 15 is followed by slot 0. Code Fh marks all sixteen slots.
- R5: A select value of 0 lets no hardware input start a burst. A select value s from 1 to 127 makes only input hw_trig[s] able to start one.
- R6: A burst starts on a 0-to-1 change of the selected input. A level held high starts no further burst. An edge that arrives while any slot of the previous burst has not yet finished converting is ignored.
- R7: Each 1 bit on sw_force marks the matching slot pending in the next cycle, whatever the enable and select fields hold.
- R8: A conversion is requested only while none is in flight. The request names the first pending slot at or after the pointer, searching circularly. That slot's pending flag clears when the request is accepted (conv_req and conv_ready both high). When conv_done ends the conversion, the pointer becomes that slot + 1, modulo 16.
- R9: A burst that marks a slot already pending sets that slot's overflow flag. Each 1 bit on ovf_clr clears the matching flag and each 0 bit leaves it alone. A set and a clear in the same cycle leave the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read value |
| hw_trig | input | 128 | Hardware trigger candidates, index = select value (bit 0 unused) |
| sw_force | input | 16 | Software force, one bit per slot |
| ovf_clr | input | 16 | Overflow clear, write-1-to-clear per slot |
| pend | output | 16 | Pending flags |
| ovf | output | 16 | Overflow flags |
| rr_ptr | output | 4 | Round-robin pointer |
| conv_req | output | 1 | Conversion request |
| conv_slot | output | 4 | Slot named by the request |
| conv_ready | input | 1 | Converter accepts the request |
| conv_done | input | 1 | Converter finished the slot in flight |

## Verification
Bursts are fired at the pointer in three positions: at zero, mid-range, and just below the wrap. The lengths used are 1, 2, 4, 6 and 16 slots. Together these separate a correct modulo walk and length decode from an off-by-one, and show whether the full-length code wraps or saturates. Trigger patterns cover a clean pulse, a level held across a whole burst, a second edge while the burst is still draining, and edges on inputs that are not selected, including the top index. Each one tells edge detection and the outstanding-burst lockout apart from level sensing and from a miswired select. Overflow is driven by forcing slots before a burst lands on them, and by a clear that hits in the same cycle as a new set.

// File: rtl/adc_burst_seq.sv
module adc_burst_seq #(
  parameter int NSLOT  = 16,
  parameter int TSEL_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [15:0]              cfg_wdata,
  output logic [15:0]              cfg_rdata,
  input  logic [(1<<TSEL_W)-1:0]   hw_trig,
  input  logic [NSLOT-1:0]         sw_force,
  input  logic [NSLOT-1:0]         ovf_clr,
  output logic [NSLOT-1:0]         pend,
  output logic [NSLOT-1:0]         ovf,
  output logic [$clog2(NSLOT)-1:0] rr_ptr,
  output logic                     conv_req,
  output logic [$clog2(NSLOT)-1:0] conv_slot,
  input  logic                     conv_ready,
  input  logic                     conv_done
);
  localparam int PW = $clog2(NSLOT);

  logic              en_q;
  logic [PW-1:0]     len_q;
  logic [TSEL_W-1:0] sel_q;
  logic              trig_q;
  logic              busy_q;
  logic [PW-1:0]     cur_q;
  logic [NSLOT-1:0]  own_q;

  logic              trig_now, burst_go, found, accept, done_ok;
  logic [NSLOT-1:0]  mark, take, fin;
  logic [PW-1:0]     pick;

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[15] = en_q;
    cfg_rdata[8 +: PW] = len_q;
    cfg_rdata[0 +: TSEL_W] = sel_q;
  end

  assign trig_now = hw_trig[sel_q];
  assign burst_go = en_q && (sel_q != '0) && trig_now && !trig_q && (own_q == '0);

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      mark[i] = burst_go && ((PW'(i) - rr_ptr) <= len_q);
  end

  always_comb begin
    logic [PW-1:0] idx;
    found = 1'b0;
    pick  = rr_ptr;
    for (int k = 0; k < NSLOT; k++) begin
      idx = rr_ptr + PW'(k);
      if (!found && pend[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  assign conv_req  = found && !busy_q;
  assign conv_slot = pick;
  assign accept    = conv_req && conv_ready;
  assign done_ok   = busy_q && conv_done;
  assign take      = accept  ? (NSLOT'(1) << pick)  : '0;
  assign fin       = done_ok ? (NSLOT'(1) << cur_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      len_q  <= '0;
      sel_q  <= '0;
      trig_q <= 1'b0;
      busy_q <= 1'b0;
      cur_q  <= '0;
      own_q  <= '0;
      pend   <= '0;
      ovf    <= '0;
      rr_ptr <= '0;
    end else begin
      if (cfg_we) begin
        en_q  <= cfg_wdata[15];
        len_q <= cfg_wdata[8 +: PW];
        sel_q <= cfg_wdata[0 +: TSEL_W];
      end
      trig_q <= trig_now;
      pend   <= (pend & ~take) | mark | sw_force;
      ovf    <= (ovf & ~ovf_clr) | (mark & pend);
      own_q  <= (own_q & ~fin) | mark;
      if (accept) begin
        busy_q <= 1'b1;
        cur_q  <= pick;
      end else if (done_ok) begin
        busy_q <= 1'b0;
      end
      if (done_ok) rr_ptr <= cur_q + PW'(1);
    end
  end

  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !conv_req);

  assert_req_is_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> pend[conv_slot]);

  assert_clear_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mark[conv_slot] && !sw_force[conv_slot]) |=> !pend[$past(conv_slot)]);

  assert_ptr_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> rr_ptr == $past(cur_q) + PW'(1));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (mark == '0));

  assert_no_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q != '0) |-> (mark == '0));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (($past(ovf) & ~$past(ovf_clr) & ~ovf) == '0));

  assert_ptr_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ok |=> $stable(rr_ptr));
endmodule

// File: tb/adc_burst_seq_bench.sv
module adc_burst_seq_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [15:0]  cfg_wdata = '0;
  logic [15:0]  cfg_rdata;
  logic [127:0] hw_trig = '0;
  logic [15:0]  sw_force = '0;
  logic [15:0]  ovf_clr = '0;
  logic [15:0]  pend, ovf;
  logic [3:0]   rr_ptr, conv_slot;
  logic         conv_req;
  logic         conv_ready = 1'b0;
  logic         conv_done = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  adc_burst_seq u_adc_burst_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hw_trig(hw_trig), .sw_force(sw_force),
    .ovf_clr(ovf_clr), .pend(pend), .ovf(ovf), .rr_ptr(rr_ptr),
    .conv_req(conv_req), .conv_slot(conv_slot), .conv_ready(conv_ready),
    .conv_done(conv_done));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(bit en, int len, int sel);
    return {en, 3'b000, 4'(len), 1'b0, 7'(sel)};
  endfunction

  task automatic cfg_write(logic [15:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(int s);
    @(negedge clk); hw_trig[s] = 1'b1;
    @(negedge clk); hw_trig[s] = 1'b0;
  endtask

  task automatic serve(string req, int n, int start);
    for (int k = 0; k < n; k++) begin
      int w = 0;
      while (!conv_req && w < 20) begin @(negedge clk); w++; end
      chk(req, "request present", int'(conv_req), 1);
      chk(req, "served slot", int'(conv_slot), (start + k) % 16);
      conv_ready = 1'b1;
      @(negedge clk); conv_ready = 1'b0; conv_done = 1'b1;
      @(negedge clk); conv_done = 1'b0;
    end
    chk(req, "pointer after burst", int'(rr_ptr), (start + n) % 16);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "cfg", int'(cfg_rdata), 0);
    chk("R1", "pend", int'(pend), 0);
    chk("R1", "ovf", int'(ovf), 0);
    chk("R1", "ptr", int'(rr_ptr), 0);
    chk("R1", "req", int'(conv_req), 0);
  endtask

  task automatic t_cfg;
    cfg_write(16'hFFFF);
    chk("R2", "readback", int'(cfg_rdata), 16'h8F7F);
    cfg_write(cw(0, 3, 5));
    chk("R2", "readback2", int'(cfg_rdata), 16'h0305);
  endtask

  task automatic t_disabled;
    pulse(5);
    @(negedge clk);
    chk("R3", "no burst when disabled", int'(pend), 0);
  endtask

  task automatic t_sel_zero;
    cfg_write(cw(1, 3, 0));
    @(negedge clk); hw_trig = '1;
    @(negedge clk); hw_trig = '0;
    @(negedge clk);
    chk("R5", "select 0 ignores hardware", int'(pend), 0);
  endtask

  task automatic t_basic;
    cfg_write(cw(1, 3, 5));
    pulse(5);
    chk("R4", "four slots from 0", int'(pend), 16'h000F);
    pulse(5);
    pulse(6);
    @(negedge clk);
    chk("R6", "edge during burst ignored", int'(pend), 16'h000F);
    chk("R6", "no overflow from ignored edge", int'(ovf), 0);
    serve("R8", 4, 0);
    chk("R8", "pend drained", int'(pend), 0);
  endtask

  task automatic t_level;
    cfg_write(cw(1, 1, 5));
    @(negedge clk); hw_trig[5] = 1'b1;
    @(negedge clk);
    chk("R4", "two slots from 4", int'(pend), 16'h0030);
    serve("R8", 2, 4);
    repeat (3) @(negedge clk);
    chk("R6", "held level no retrigger", int'(pend), 0);
    hw_trig[5] = 1'b0;
    pulse(5);
    chk("R6", "new edge fires", int'(pend), 16'h00C0);
    serve("R8", 2, 6);
  endtask

  task automatic t_wrap;
    cfg_write(cw(1, 5, 5));
    pulse(5);
    chk("R4", "six slots from 8", int'(pend), 16'h3F00);
    serve("R8", 6, 8);
    cfg_write(cw(1, 3, 5));
    pulse(5);
    chk("R4", "wrap 14,15,0,1", int'(pend), 16'hC003);
    serve("R8", 4, 14);
  endtask

  task automatic t_full;
    cfg_write(cw(1, 15, 5));
    pulse(5);
    chk("R4", "all sixteen", int'(pend), 16'hFFFF);
    chk("R9", "no overflow on empty slots", int'(ovf), 0);
    serve("R8", 16, 2);
  endtask

  task automatic t_force;
    cfg_write(cw(0, 0, 0));
    @(negedge clk); sw_force = 16'h0120;
    @(negedge clk); sw_force = '0;
    chk("R7", "force marks slots", int'(pend), 16'h0120);
    serve("R7", 1, 5);
    serve("R7", 1, 8);
  endtask

  task automatic t_ovf;
    @(negedge clk); sw_force = 16'h0600;
    @(negedge clk); sw_force = '0;
    cfg_write(cw(1, 3, 7));
    pulse(7);
    chk("R9", "pend after overlap", int'(pend), 16'h1E00);
    chk("R9", "ovf set on overlap", int'(ovf), 16'h0600);
    @(negedge clk); ovf_clr = 16'h0200;
    @(negedge clk); ovf_clr = '0;
    chk("R9", "w1c clears only bit 9", int'(ovf), 16'h0400);
    serve("R9", 4, 9);
    @(negedge clk); sw_force = 16'h2000;
    @(negedge clk); sw_force = '0; hw_trig[7] = 1'b1; ovf_clr = 16'h2400;
    @(negedge clk); hw_trig[7] = 1'b0; ovf_clr = '0;
    chk("R9", "set wins over clear", int'(ovf), 16'h2000);
    chk("R9", "pend after wrap burst", int'(pend), 16'hE001);
    serve("R9", 4, 13);
    @(negedge clk); ovf_clr = 16'h2000;
    @(negedge clk); ovf_clr = '0;
    chk("R9", "all cleared", int'(ovf), 0);
  endtask

  task automatic t_sel_top;
    cfg_write(cw(1, 0, 127));
    pulse(5);
    pulse(126);
    @(negedge clk);
    chk("R5", "unselected inputs ignored", int'(pend), 0);
    pulse(127);
    chk("R5", "input 127 fires one slot", int'(pend), 16'h0002);
    serve("R5", 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_cfg;
    t_disabled;
    t_sel_zero;
    t_basic;
    t_level;
    t_wrap;
    t_full;
    t_force;
    t_ovf;
    t_sel_top;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule